// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

The block gathers raw active-high interrupt requests, arranged in banks of 32 lines, and drives two interrupt outputs: a normal class and a fast class. Each line has its own configuration word. The word gives a 5-bit priority, selects edge or level sensitivity, and routes the line to one of the two classes. Every bank has a pending register, a mask register and a software-set register. Bank 0 also holds one source-code register for each class and a control register. Software reaches all of these over a simple 32-bit register bus. Writes take effect on the clock edge. Read data is combinational while a read is presented, and any side effect of the read happens on the clock edge that ends the access.

Each class has its own priority arbiter. It picks a winner among the lines that are pending, unmasked and routed to that class. An output rises only while its class is armed. When it rises, the class is disarmed and the winner's code is latched. The output then stays high, and the code stays fixed, until software re-arms the class through the control register. Reading a source code acknowledges the latched line: an edge line loses its pending bit, and a level line keeps it.

Top module: `banked_intc`

## Requirements
- R1: After reset every mask register reads 0xFFFFFFFF. All pending bits and all line configuration words read zero. Both classes are armed, and both outputs are low.
- R2: Address bits above bit 7 select the bank, and bits 7:0 give the offset. The offsets are: pending 0x00, mask 0x04, normal code 0x10, fast code 0x14, control 0x18, configuration of line n at 0x1C+4n, software set 0x9C. The codes and control exist only in bank 0. Any other offset reads zero, and a write to it changes nothing.
- R3: Configuration word layout: bits 6:2 priority, bit 1 level sensitivity (1 = level, 0 = edge), bit 0 routes the line to the fast class. Only these seven bits are stored.
- R4: An edge line becomes pending when its request is sampled high after being low. The bit stays set when the request drops. A request that is held high does not set the bit again.
- R5: A level line is pending while its request is high. The bit clears one cycle after the request drops.
- R6: A write to a pending register ANDs the register with the written value. A level line whose request is still high keeps its bit.
- R7: The winner of a class has the smallest priority value among the lines that are pending, unmasked and routed to that class. A tie goes to the higher line number. The code is 32*bank + line.
- R8: An armed class with a qualifying line raises its output on the next clock edge and latches the winner's code. The output and the code then hold, even if the pending bit is cleared, until that class is re-armed.
- R9: Writing 1 to control bit 0 (normal) or bit 1 (fast) drops that output on the same edge and re-arms the class. If a line still qualifies, the output rises again one cycle later.
- R10: Reading a source code clears the pending bit of the latched line if that line is edge-sensitive. A level line's bit is left unchanged.
- R11: A write to the software-set register sets the pending bit of only the lowest set bit of the written value.
- R12: A masked line never qualifies. Clearing its mask bit lets an armed class assert without any other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_BANKS*32 | Raw active-high request lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8+BANK_W | Register address (bank and offset) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is presented |
| irq_norm | output | 1 | Normal-class interrupt output |
| irq_fast | output | 1 | Fast-class interrupt output |

## Verification
The bench targets priority ties that cross the bank boundary. A design that scans in the wrong direction, or that keeps the first candidate on a tie, would report the lower-numbered line. It checks that an acknowledge clears edge lines but leaves level lines whose request is high. Getting either wrong loses interrupts or leaves them stuck. It also checks that a pending write cannot drop a live level request, and that software set takes only the lowest bit. Finally, it checks that outputs and codes stay latched across pending changes until re-armed. A design that tracks the arbiter live would change the code under software's feet.

// File: rtl/bintc_pkg.sv
// Shared constants and types for the banked interrupt controller.
// Assumes 32 lines per bank and a byte-addressed 256-byte bank window.
package bintc_pkg;
    localparam int LINES  = 32;
    localparam int PRIO_W = 5;
    localparam int CFG_W  = PRIO_W + 2;

    localparam logic [7:0] OFF_PEND   = 8'h00;
    localparam logic [7:0] OFF_MASK   = 8'h04;
    localparam logic [7:0] OFF_CODE_N = 8'h10;
    localparam logic [7:0] OFF_CODE_F = 8'h14;
    localparam logic [7:0] OFF_CTRL   = 8'h18;
    localparam logic [7:0] OFF_CFG0   = 8'h1C;
    localparam logic [7:0] OFF_CFGL   = 8'h98;
    localparam logic [7:0] OFF_SWSET  = 8'h9C;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              level;
        logic              fast;
    } line_cfg_t;
endpackage

// File: rtl/bintc_bank.sv
// One bank of 32 lines: pending, mask and per-line configuration state.
// Assumes wr_en is already qualified by bank selection; ack_clr marks the
// line whose source code was read this cycle.
module bintc_bank
    import bintc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LINES-1:0]        req,
    input  logic                    wr_en,
    input  logic [7:0]              off,
    input  logic [31:0]             wdata,
    input  logic [LINES-1:0]        ack_clr,
    output logic [LINES-1:0]        pend_o,
    output logic [LINES-1:0]        mask_o,
    output logic [LINES-1:0]        fast_o,
    output logic [LINES*PRIO_W-1:0] prio_o,
    output logic [31:0]             rdata_o
);
    logic [LINES-1:0] pend, pend_nxt, mask, in_q, level;
    line_cfg_t        cfg [LINES];
    logic             is_cfg;
    logic [4:0]       cfg_idx;

    assign is_cfg  = (off >= OFF_CFG0) && (off <= OFF_CFGL) && (off[1:0] == 2'b00);
    assign cfg_idx = 5'((off - OFF_CFG0) >> 2);

    // Unpack the per-line configuration into flat vectors.
    for (genvar i = 0; i < LINES; i++) begin : g_unpack
        assign level[i]                    = cfg[i].level;
        assign fast_o[i]                   = cfg[i].fast;
        assign prio_o[i*PRIO_W +: PRIO_W]  = cfg[i].prio;
    end

    // Remember the previous raw request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= req;
    end

    // Mask register: all lines masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                           mask <= '1;
        else if (wr_en && off == OFF_MASK)    mask <= wdata;
    end

    // Per-line configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) cfg[i] <= '0;
        end else if (wr_en && is_cfg) begin
            cfg[cfg_idx] <= line_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    // Next pending state: bus effects first, then hardware requests win.
    always_comb begin
        pend_nxt = pend;
        if (wr_en && off == OFF_PEND)
            pend_nxt = pend_nxt & (wdata | (req & level));
        if (wr_en && off == OFF_SWSET)
            pend_nxt = pend_nxt | (wdata & (~wdata + 32'd1));
        pend_nxt = pend_nxt & ~(ack_clr & ~level);
        pend_nxt = pend_nxt | (req & ~in_q & ~level) | (req & level);
        pend_nxt = pend_nxt & ~(~req & in_q & level);
    end

    // Pending register update.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end

    // Per-bank read data; offsets not owned by the bank read zero.
    always_comb begin
        rdata_o = '0;
        if (off == OFF_PEND)      rdata_o = pend;
        else if (off == OFF_MASK) rdata_o = mask;
        else if (is_cfg)          rdata_o = {{(32-CFG_W){1'b0}}, cfg[cfg_idx]};
    end

    assign pend_o = pend;
    assign mask_o = mask;
endmodule

// File: rtl/bintc_arb.sv
// Priority arbiter across all lines of one class.
// Assumes lower priority value wins and ties go to the higher line index.
module bintc_arb
    import bintc_pkg::*;
#(
    parameter int N_LINES = 64,
    parameter int CODE_W  = 6
) (
    input  logic [N_LINES-1:0]        qual,
    input  logic [N_LINES*PRIO_W-1:0] prio,
    output logic                      any,
    output logic [CODE_W-1:0]         win
);
    logic [PRIO_W-1:0] best;

    // Linear scan: a later line with equal or better priority replaces the winner.
    always_comb begin
        best = '1;
        win  = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (qual[i] && prio[i*PRIO_W +: PRIO_W] <= best) begin
                best = prio[i*PRIO_W +: PRIO_W];
                win  = CODE_W'(i);
            end
        end
    end

    assign any = |qual;
endmodule

// File: rtl/bintc_out.sv
// Output latch for one class: arm flag, interrupt line and latched code.
// Assumes rearm_wr is a single-cycle pulse from the control register.
module bintc_out #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rearm_wr,
    input  logic              any,
    input  logic [CODE_W-1:0] win,
    output logic              irq_o,
    output logic [CODE_W-1:0] code_o
);
    logic armed;

    // Arm, fire and latch sequence for the class output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b1;
            irq_o  <= 1'b0;
            code_o <= '0;
        end else if (rearm_wr) begin
            armed  <= 1'b1;
            irq_o  <= 1'b0;
        end else if (armed && any) begin
            armed  <= 1'b0;
            irq_o  <= 1'b1;
            code_o <= win;
        end
    end
endmodule

// File: rtl/banked_intc.sv
// Top of the banked interrupt controller: bus decode, banks, two class paths.
// Assumes a single-cycle register bus with combinational read data; read
// side effects (acknowledge) occur on the clock edge ending the access.
module banked_intc
    import bintc_pkg::*;
#(
    parameter  int NUM_BANKS = 2,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = 8 + BANK_W,
    localparam int N_LINES   = NUM_BANKS * LINES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_req,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_norm,
    output logic               irq_fast
);
    localparam int CODE_W = $clog2(N_LINES);

    logic [BANK_W-1:0]               bank_sel;
    logic [7:0]                      off;
    logic                            bank_ok, is_b0, ctl_wr;
    logic [1:0]                      rearm_wr, ack_rd, any_c, irq_c;
    logic [1:0][CODE_W-1:0]          win_c, code_q;
    logic [1:0][N_LINES-1:0]         qual;
    logic [N_LINES-1:0]              pend_all, mask_all, fast_all, ack_vec;
    logic [N_LINES*PRIO_W-1:0]       prio_all;
    logic [31:0]                     bank_rdata [NUM_BANKS];

    assign bank_sel = bus_addr[ADDR_W-1:8];
    assign off      = bus_addr[7:0];
    assign bank_ok  = (32'(bank_sel) < NUM_BANKS);
    assign is_b0    = bank_ok && (bank_sel == '0);
    assign ctl_wr   = bus_sel && bus_wr && is_b0 && (off == OFF_CTRL);
    assign rearm_wr = {ctl_wr & bus_wdata[1], ctl_wr & bus_wdata[0]};
    assign ack_rd   = {bus_sel && !bus_wr && is_b0 && (off == OFF_CODE_F),
                       bus_sel && !bus_wr && is_b0 && (off == OFF_CODE_N)};

    // One-hot acknowledge of the latched line(s) being read.
    always_comb begin
        ack_vec = '0;
        if (ack_rd[0]) ack_vec = ack_vec | (N_LINES'(1) << code_q[0]);
        if (ack_rd[1]) ack_vec = ack_vec | (N_LINES'(1) << code_q[1]);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bintc_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (irq_req[b*LINES +: LINES]),
            .wr_en   (bus_sel && bus_wr && bank_ok && (32'(bank_sel) == b)),
            .off     (off),
            .wdata   (bus_wdata),
            .ack_clr (ack_vec[b*LINES +: LINES]),
            .pend_o  (pend_all[b*LINES +: LINES]),
            .mask_o  (mask_all[b*LINES +: LINES]),
            .fast_o  (fast_all[b*LINES +: LINES]),
            .prio_o  (prio_all[b*LINES*PRIO_W +: LINES*PRIO_W]),
            .rdata_o (bank_rdata[b])
        );
    end

    for (genvar c = 0; c < 2; c++) begin : g_cls
        assign qual[c] = pend_all & ~mask_all & ((c == 1) ? fast_all : ~fast_all);

        bintc_arb #(.N_LINES(N_LINES), .CODE_W(CODE_W)) u_arb (
            .qual (qual[c]),
            .prio (prio_all),
            .any  (any_c[c]),
            .win  (win_c[c])
        );

        bintc_out #(.CODE_W(CODE_W)) u_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .rearm_wr (rearm_wr[c]),
            .any      (any_c[c]),
            .win      (win_c[c]),
            .irq_o    (irq_c[c]),
            .code_o   (code_q[c])
        );
    end

    // Read mux: bank-0 code registers, otherwise the selected bank.
    always_comb begin
        bus_rdata = '0;
        if (bank_ok) begin
            if (is_b0 && off == OFF_CODE_N)      bus_rdata = 32'(code_q[0]);
            else if (is_b0 && off == OFF_CODE_F) bus_rdata = 32'(code_q[1]);
            else                                 bus_rdata = bank_rdata[bank_sel];
        end
    end

    assign irq_norm = irq_c[0];
    assign irq_fast = irq_c[1];
endmodule

// File: rtl/bintc_chk.sv
// Assertion checker for banked_intc, attached through bind.
// Assumes the class signals of the top are visible at bind scope.
module bintc_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_norm,
    input logic              irq_fast,
    input logic [1:0]        any_c,
    input logic [1:0]        rearm_c,
    input logic [CODE_W-1:0] code_n,
    input logic [CODE_W-1:0] code_f,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [7:0]        off,
    input logic [31:0]       bus_rdata
);
    AST_RISE_NEEDS_QUAL_N: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_norm) |-> $past(any_c[0])); // R8
    AST_RISE_NEEDS_QUAL_F: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_fast) |-> $past(any_c[1])); // R8
    AST_HOLD_N: assert property (@(posedge clk) disable iff (!rst_n) (irq_norm && !rearm_c[0]) |=> irq_norm); // R8
    AST_HOLD_F: assert property (@(posedge clk) disable iff (!rst_n) (irq_fast && !rearm_c[1]) |=> irq_fast); // R8
    AST_CODE_HOLD_N: assert property (@(posedge clk) disable iff (!rst_n) !$rose(irq_norm) |-> $stable(code_n)); // R8
    AST_CODE_HOLD_F: assert property (@(posedge clk) disable iff (!rst_n) !$rose(irq_fast) |-> $stable(code_f)); // R8
    AST_REARM_DROP_N: assert property (@(posedge clk) disable iff (!rst_n) rearm_c[0] |=> !irq_norm); // R9
    AST_REARM_DROP_F: assert property (@(posedge clk) disable iff (!rst_n) rearm_c[1] |=> !irq_fast); // R9
    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_sel && !bus_wr && off == 8'h08) |-> bus_rdata == 32'd0); // R2
endmodule

bind banked_intc bintc_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_norm  (irq_norm),
    .irq_fast  (irq_fast),
    .any_c     (any_c),
    .rearm_c   (rearm_wr),
    .code_n    (code_q[0]),
    .code_f    (code_q[1]),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .off       (bus_addr[7:0]),
    .bus_rdata (bus_rdata)
);

// File: tb/sim_banked_intc.sv
// Self-checking bench for banked_intc (two banks, 64 lines).
module sim_banked_intc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] req = '0;
    logic        sel = 1'b0, wrn = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;
    logic        irq_norm, irq_fast;
    int          nchk = 0, nerr = 0;

    logic [4:0]  prio_m [64];
    logic        fast_m [64];
    logic [63:0] pend_m, mask_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_intc #(.NUM_BANKS(2)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(req), .bus_sel(sel), .bus_wr(wrn),
        .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rdata),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1'b1; wrn = 1'b1; addr = a; wd = d;
        @(negedge clk); sel = 1'b0; wrn = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1'b1; wrn = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk); sel = 1'b0;
    endtask

    function automatic logic [8:0] cfg_a(input int line);
        return {1'(line / 32), 8'(8'h1C + 4 * (line % 32))};
    endfunction

    // Reference arbitration over the bench's own model of the lines.
    function automatic int exp_win(input bit fastc, output bit found);
        int best = 32, w = 0;
        found = 1'b0;
        for (int i = 0; i < 64; i++)
            if (pend_m[i] && !mask_m[i] && fast_m[i] == fastc && int'(prio_m[i]) <= best) begin
                best = int'(prio_m[i]); w = i; found = 1'b1;
            end
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit f;
        int w;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(9'h004, v); chk("R1 mask b0", v, 32'hFFFFFFFF);
        rd(9'h104, v); chk("R1 mask b1", v, 32'hFFFFFFFF);
        rd(9'h000, v); chk("R1 pend b0", v, 0);
        rd(cfg_a(5), v); chk("R1 cfg5", v, 0);
        chk("R1 irq_norm", 32'(irq_norm), 0);
        chk("R1 irq_fast", 32'(irq_fast), 0);

        // R2 undefined offsets and bank-0-only registers
        wr(9'h008, 32'hDEAD); rd(9'h008, v); chk("R2 undef", v, 0);
        rd(9'h110, v); chk("R2 code only bank0", v, 0);

        // R3 configuration layout
        wr(cfg_a(3), 32'h7F); rd(cfg_a(3), v); chk("R3 cfg rw", v, 32'h7F);
        wr(cfg_a(4), 32'hFFFFFFFF); rd(cfg_a(4), v); chk("R3 cfg width", v, 32'h7F);
        wr(cfg_a(3), 0); wr(cfg_a(4), 0);

        // R4 edge line
        req[2] = 1'b1; rd(9'h000, v); chk("R4 edge set", v, 32'h4);
        wr(9'h000, 0); rd(9'h000, v); chk("R4 held high no reset", v, 0);
        req[2] = 1'b0; @(negedge clk); req[2] = 1'b1;
        @(negedge clk); req[2] = 1'b0;
        rd(9'h000, v); chk("R4 stays after drop", v, 32'h4);
        wr(9'h000, 0);

        // R5/R6 level line
        wr(cfg_a(7), 32'h2); req[7] = 1'b1;
        rd(9'h000, v); chk("R5 level set", v, 32'h80);
        wr(9'h000, 0); rd(9'h000, v); chk("R6 level protected", v, 32'h80);
        req[7] = 1'b0; rd(9'h000, v); chk("R5 level drop clears", v, 0);

        // R6 AND semantics
        wr(9'h09C, 32'h10); wr(9'h09C, 32'h20); wr(9'h000, 32'h20);
        rd(9'h000, v); chk("R6 and", v, 32'h20);
        wr(9'h000, 0);

        // R11 software set takes lowest bit
        wr(9'h09C, 32'h0A00); rd(9'h000, v); chk("R11 lowest b0", v, 32'h200);
        wr(9'h19C, 32'h30); rd(9'h100, v); chk("R11 lowest b1", v, 32'h10);
        wr(9'h000, 0); wr(9'h100, 0);

        // R7/R8/R9/R10/R12 arbitration and output latching
        wr(cfg_a(9), 32'hC); wr(cfg_a(20), 32'hC); wr(cfg_a(36), 32'hC);
        wr(9'h09C, 32'h200); wr(9'h09C, 32'h100000); wr(9'h19C, 32'h10);
        chk("R12 masked no irq", 32'(irq_norm), 0);
        wr(9'h104, 0); @(negedge clk);
        chk("R12 unmask asserts", 32'(irq_norm), 1);
        wr(9'h004, 0);
        rd(9'h010, v); chk("R7 tie highest line", v, 36);
        rd(9'h100, v); chk("R10 edge acked", v, 0);
        chk("R8 held after ack", 32'(irq_norm), 1);
        wr(9'h018, 1); chk("R9 drop on rearm", 32'(irq_norm), 0);
        @(negedge clk); chk("R9 reassert", 32'(irq_norm), 1);
        rd(9'h010, v); chk("R7 next winner", v, 20);
        wr(cfg_a(9), 32'h4); wr(9'h09C, 32'h100000); wr(9'h19C, 32'h10);
        wr(9'h018, 1); @(negedge clk);
        rd(9'h010, v); chk("R7 lowest prio wins", v, 9);

        // R3 fast routing
        wr(cfg_a(9), 32'h5); wr(9'h09C, 32'h200); @(negedge clk);
        chk("R3 fast route irq", 32'(irq_fast), 1);
        rd(9'h014, v); chk("R3 fast code", v, 9);
        wr(9'h018, 3);
        chk("R9 fast drop", 32'(irq_fast), 0);
        chk("R9 norm drop", 32'(irq_norm), 0);
        @(negedge clk);
        chk("R9 fast stays low", 32'(irq_fast), 0);
        chk("R9 norm reasserts", 32'(irq_norm), 1);
        rd(9'h010, v); chk("R7 code after rearm", v, 36);

        // R10 level line not cleared by acknowledge
        wr(9'h004, 32'hFFFFFFFF); wr(9'h104, 32'hFFFFFFFF);
        wr(9'h000, 0); wr(9'h100, 0);
        wr(cfg_a(7), 32'h2); wr(9'h004, ~32'h80); wr(9'h018, 3);
        req[7] = 1'b1; repeat (2) @(negedge clk);
        chk("R10 level irq", 32'(irq_norm), 1);
        rd(9'h010, v); chk("R10 level code", v, 7);
        rd(9'h000, v); chk("R10 level kept", v, 32'h80);
        req[7] = 1'b0; @(negedge clk);

        // Random arbitration rounds (R7, R8, R12)
        for (int it = 0; it < 20; it++) begin
            wr(9'h004, 32'hFFFFFFFF); wr(9'h104, 32'hFFFFFFFF);
            wr(9'h000, 0); wr(9'h100, 0);
            for (int l = 0; l < 64; l++) begin
                prio_m[l] = 5'($urandom % 32);
                fast_m[l] = ($urandom % 4) == 0;
                wr(cfg_a(l), {25'd0, prio_m[l], 1'b0, fast_m[l]});
            end
            pend_m = '0;
            for (int l = 0; l < 64; l++)
                if ($urandom % 5 == 0) begin
                    pend_m[l] = 1'b1;
                    wr({1'(l / 32), 8'h9C}, 32'd1 << (l % 32));
                end
            mask_m = {$urandom & $urandom, $urandom & $urandom};
            wr(9'h004, mask_m[31:0]); wr(9'h104, mask_m[63:32]);
            wr(9'h018, 3); @(negedge clk);
            w = exp_win(1'b0, f);
            chk("R8 rand norm irq", 32'(irq_norm), 32'(f));
            if (f) begin rd(9'h010, v); chk("R7 rand norm code", v, w); end
            w = exp_win(1'b1, f);
            chk("R8 rand fast irq", 32'(irq_fast), 32'(f));
            if (f) begin rd(9'h014, v); chk("R7 rand fast code", v, w); end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule